// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block models how a byte-wide parallel NOR flash answers reads while an embedded program or erase runs inside it. It holds a small sectored byte array and accepts single-cycle command pulses: program one byte, erase a chosen set of sectors, erase every sector, suspend an erase, resume it, and a reset command that clears a timed-out operation. A command pulse stands for the last write-enable rising edge of the full command sequence, so status becomes valid from the cycle after the pulse. Unlocking sequences, toggle bits and cell physics are not modelled.

During an operation a read returns a status byte instead of array contents. Bit 7 is the polling bit: for a program it is the inverse of bit 7 of the byte being written until the write lands, and for an erase it is 0 while the erase runs and 1 while it is suspended. Bit 5 reports a program that overran its time limit. Commands aimed only at locked sectors do not touch the array, but still poll for a fixed window (about 2 µs for a program, about 100 µs for an erase) counted in clock cycles from a clock-frequency parameter.

The read port is a plain strobe with fixed latency: `rd_en` in one cycle gives `rd_data` and `rd_valid` in the next. The block never stalls a read, so the port has no back-pressure; `rd_data` holds its last value between reads. Addresses are `{sector, offset}`, the sector index in the upper bits.

Top module: `fstat_flash`

## Requirements
- R1: After reset every array byte reads 0xFF, and `rd_valid` is high exactly in the cycle after each cycle with `rd_en` high, carrying the data for that read.
- R2: While a program runs (PROG_CYC cycles after the pulse), every read returns the status byte with bit 7 equal to the inverse of bit 7 of the programmed data, bit 5 equal to the timeout flag, and all other bits 0.
- R3: When a program finishes, the target byte becomes old AND data and reads then return array data, so bit 7 shows its true value.
- R4: A program to a locked sector polls like R2 for CLK_MHZ*2 cycles, then reads return array data with the byte unchanged.
- R5: While an erase runs (ERASE_CYC cycles), every read returns 0x00; on completion the selected unlocked sectors read 0xFF and locked or unselected sectors keep their bytes. Chip erase selects every sector.
- R6: An erase whose selected sectors are all locked reads 0x00 for CLK_MHZ*100 cycles, then reads return the unchanged array.
- R7: While an erase is suspended, reads in a sector being erased return 0x80 and reads elsewhere return array data; resume continues the erase where it stopped.
- R8: A program issued during suspend to a sector not being erased shows the same inverse/true bit 7 behaviour, then the block returns to the suspended state.
- R9: A program that would need a 0 bit raised to 1 never completes; after LIMIT_CYC cycles bit 5 reads 1 and stays 1 until a reset command, which returns to array reads with nothing written.
- R10: Commands that the current state does not accept (a program or erase while busy, a program after a timeout) are ignored and change no array byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_prog | input | 1 | Program command pulse |
| cmd_serase | input | 1 | Sector erase command pulse, uses `erase_sel` |
| cmd_cerase | input | 1 | Chip erase command pulse |
| cmd_susp | input | 1 | Erase suspend pulse |
| cmd_resume | input | 1 | Erase resume pulse |
| cmd_reset | input | 1 | Reset command pulse, clears a timed-out program |
| cmd_addr | input | log2(SECTORS*SECTOR_BYTES) | Program target address |
| cmd_data | input | 8 | Program data |
| erase_sel | input | SECTORS | Sectors chosen for sector erase |
| sect_lock | input | SECTORS | Per-sector lock flags |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | log2(SECTORS*SECTOR_BYTES) | Read address |
| rd_data | output | 8 | Read result, status or array byte |
| rd_valid | output | 1 | High one cycle after `rd_en` |

## Verification
Programs are driven with data whose bit 7 is 0 and with data whose bit 7 is 1, so a polling bit stuck at one value or not inverted is caught, and reads before and after completion separate the busy and done phases. A program that would raise a cleared bit tells the AND rule from a plain overwrite and exercises the sticky timeout. Erases are tried with a partly locked selection, a fully locked selection, a chip erase and a suspended erase with a nested program, which tell apart the lock filtering, the long polling window, and reads inside and outside the erasing sectors during suspend.

// File: rtl/fstat_pkg.sv
package fstat_pkg;
  typedef enum logic [2:0] {
    ST_READ  = 3'd0,
    ST_PROG  = 3'd1,
    ST_PLOCK = 3'd2,
    ST_ERASE = 3'd3,
    ST_ELOCK = 3'd4,
    ST_SUSP  = 3'd5
  } fst_state_e;
endpackage

// File: rtl/fstat_store.sv
module fstat_store #(
  parameter int SECTORS      = 8,
  parameter int SECTOR_BYTES = 16,
  parameter int AW           = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               ers_en,
  input  logic [SECTORS-1:0] ers_mask,
  input  logic [AW-1:0]      rd_addr,
  output logic [7:0]         rd_byte,
  input  logic [AW-1:0]      peek_addr,
  output logic [7:0]         peek_byte
);
  localparam int DEPTH = SECTORS * SECTOR_BYTES;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (ers_en) begin
        for (int i = 0; i < DEPTH; i++)
          if (ers_mask[i / SECTOR_BYTES]) mem[i] <= 8'hFF;
      end
      if (wr_en) mem[wr_addr] <= mem[wr_addr] & wr_data;
    end
  end

  assign rd_byte   = mem[rd_addr];
  assign peek_byte = mem[peek_addr];
endmodule

// File: rtl/fstat_seq.sv
module fstat_seq
  import fstat_pkg::*;
#(
  parameter int SECTORS   = 8,
  parameter int OW        = 4,
  parameter int AW        = 7,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 200,
  parameter int PLOCK_CYC = 250,
  parameter int ELOCK_CYC = 12500,
  parameter int LIMIT_CYC = 400
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_prog,
  input  logic               cmd_serase,
  input  logic               cmd_cerase,
  input  logic               cmd_susp,
  input  logic               cmd_resume,
  input  logic               cmd_reset,
  input  logic [AW-1:0]      cmd_addr,
  input  logic [7:0]         cmd_data,
  input  logic [SECTORS-1:0] erase_sel,
  input  logic [SECTORS-1:0] sect_lock,
  input  logic [7:0]         old_byte,
  output fst_state_e         state,
  output logic               poll_d7,
  output logic               timeout,
  output logic [SECTORS-1:0] ers_mask,
  output logic               wr_en,
  output logic [AW-1:0]      wr_addr,
  output logic [7:0]         wr_data,
  output logic               ers_en
);
  localparam int M1   = (PLOCK_CYC > ELOCK_CYC) ? PLOCK_CYC : ELOCK_CYC;
  localparam int M2   = (PROG_CYC > LIMIT_CYC) ? PROG_CYC : LIMIT_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int CMAX = (M3 > ERASE_CYC) ? M3 : ERASE_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int SW   = AW - OW;

  logic [CW-1:0] cnt, ecnt;
  logic          bad, ret_susp;
  logic [SW-1:0] p_sect;
  logic          p_locked, p_bad;
  logic [SECTORS-1:0] new_mask;
  logic          prog_last, ers_last;

  assign p_sect   = cmd_addr[AW-1:OW];
  assign p_locked = sect_lock[p_sect];
  assign p_bad    = |(cmd_data & ~old_byte);
  assign new_mask = cmd_cerase ? ~sect_lock : (erase_sel & ~sect_lock);

  assign prog_last = (state == ST_PROG) && !timeout && !bad && (cnt == CW'(PROG_CYC - 1));
  assign ers_last  = (state == ST_ERASE) && !cmd_susp && (ecnt == CW'(ERASE_CYC - 1));
  assign wr_en     = prog_last;
  assign ers_en    = ers_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_READ;
      cnt      <= '0;
      ecnt     <= '0;
      bad      <= 1'b0;
      ret_susp <= 1'b0;
      timeout  <= 1'b0;
      ers_mask <= '0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      case (state)
        ST_READ: begin
          if (cmd_prog) begin
            wr_addr  <= cmd_addr;
            wr_data  <= cmd_data;
            bad      <= p_bad;
            cnt      <= '0;
            ret_susp <= 1'b0;
            state    <= p_locked ? ST_PLOCK : ST_PROG;
          end else if (cmd_serase || cmd_cerase) begin
            ers_mask <= new_mask;
            cnt      <= '0;
            ecnt     <= '0;
            state    <= (new_mask == '0) ? ST_ELOCK : ST_ERASE;
          end
        end
        ST_PROG: begin
          if (timeout) begin
            if (cmd_reset) begin
              timeout  <= 1'b0;
              ers_mask <= '0;
              ret_susp <= 1'b0;
              state    <= ST_READ;
            end
          end else if (bad) begin
            if (cnt == CW'(LIMIT_CYC - 1)) timeout <= 1'b1;
            else cnt <= cnt + 1'b1;
          end else if (prog_last) begin
            state <= ret_susp ? ST_SUSP : ST_READ;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PLOCK: begin
          if (cnt == CW'(PLOCK_CYC - 1)) state <= ret_susp ? ST_SUSP : ST_READ;
          else cnt <= cnt + 1'b1;
        end
        ST_ERASE: begin
          if (cmd_susp) begin
            state <= ST_SUSP;
          end else if (ers_last) begin
            ers_mask <= '0;
            state    <= ST_READ;
          end else begin
            ecnt <= ecnt + 1'b1;
          end
        end
        ST_ELOCK: begin
          if (cnt == CW'(ELOCK_CYC - 1)) state <= ST_READ;
          else cnt <= cnt + 1'b1;
        end
        ST_SUSP: begin
          if (cmd_resume) begin
            state <= ST_ERASE;
          end else if (cmd_prog && !ers_mask[p_sect]) begin
            wr_addr  <= cmd_addr;
            wr_data  <= cmd_data;
            bad      <= p_bad;
            cnt      <= '0;
            ret_susp <= 1'b1;
            state    <= p_locked ? ST_PLOCK : ST_PROG;
          end
        end
        default: state <= ST_READ;
      endcase
    end
  end

  assign poll_d7 = wr_data[7];

  // R9: timeout flag holds until a reset command
  a_r9_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !cmd_reset) |=> timeout);

  // R7: a suspended erase always has sectors pending
  a_r7_susp_has_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUSP) |-> (ers_mask != '0));

  // R10: no program lands while a timed-out operation waits for reset
  a_r10_no_write_after_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !wr_en);
endmodule

// File: rtl/fstat_flash.sv
module fstat_flash
  import fstat_pkg::*;
#(
  parameter int SECTORS      = 8,
  parameter int SECTOR_BYTES = 16,
  parameter int CLK_MHZ      = 125,
  parameter int PROG_CYC     = 20,
  parameter int ERASE_CYC    = 200,
  parameter int LIMIT_CYC    = 400
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      cmd_prog,
  input  logic                                      cmd_serase,
  input  logic                                      cmd_cerase,
  input  logic                                      cmd_susp,
  input  logic                                      cmd_resume,
  input  logic                                      cmd_reset,
  input  logic [$clog2(SECTORS*SECTOR_BYTES)-1:0]   cmd_addr,
  input  logic [7:0]                                cmd_data,
  input  logic [SECTORS-1:0]                        erase_sel,
  input  logic [SECTORS-1:0]                        sect_lock,
  input  logic                                      rd_en,
  input  logic [$clog2(SECTORS*SECTOR_BYTES)-1:0]   rd_addr,
  output logic [7:0]                                rd_data,
  output logic                                      rd_valid
);
  localparam int OW        = $clog2(SECTOR_BYTES);
  localparam int AW        = $clog2(SECTORS * SECTOR_BYTES);
  localparam int PLOCK_CYC = CLK_MHZ * 2;
  localparam int ELOCK_CYC = CLK_MHZ * 100;

  fst_state_e         state;
  logic               poll_d7, timeout, wr_en, ers_en;
  logic [SECTORS-1:0] ers_mask;
  logic [AW-1:0]      wr_addr;
  logic [7:0]         wr_data, arr_byte, old_byte, next_rd;

  fstat_seq #(
    .SECTORS(SECTORS), .OW(OW), .AW(AW), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .PLOCK_CYC(PLOCK_CYC), .ELOCK_CYC(ELOCK_CYC),
    .LIMIT_CYC(LIMIT_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_prog(cmd_prog), .cmd_serase(cmd_serase),
    .cmd_cerase(cmd_cerase), .cmd_susp(cmd_susp), .cmd_resume(cmd_resume),
    .cmd_reset(cmd_reset), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .erase_sel(erase_sel), .sect_lock(sect_lock), .old_byte(old_byte),
    .state(state), .poll_d7(poll_d7), .timeout(timeout), .ers_mask(ers_mask),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ers_en(ers_en)
  );

  fstat_store #(
    .SECTORS(SECTORS), .SECTOR_BYTES(SECTOR_BYTES), .AW(AW)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ers_en(ers_en), .ers_mask(ers_mask),
    .rd_addr(rd_addr), .rd_byte(arr_byte),
    .peek_addr(cmd_addr), .peek_byte(old_byte)
  );

  always_comb begin
    case (state)
      ST_PROG, ST_PLOCK: next_rd = {~poll_d7, 1'b0, timeout, 5'b0};
      ST_ERASE, ST_ELOCK: next_rd = 8'h00;
      ST_SUSP:  next_rd = ers_mask[rd_addr[AW-1:OW]] ? 8'h80 : arr_byte;
      default:  next_rd = arr_byte;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= 8'h00;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= next_rd;
    end
  end

  // R1: valid follows the strobe by one cycle
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  a_r1_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R2: polling bit inverts the programmed bit 7
  a_r2_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (state == ST_PROG || state == ST_PLOCK)) |=> (rd_data[7] != $past(poll_d7)));

  // R5: erase in progress reads all zero
  a_r5_erase_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && state == ST_ERASE) |=> (rd_data == 8'h00));
endmodule

// File: tb/tb_fstat_flash.sv
module tb_fstat_flash;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_prog = 0, cmd_serase = 0, cmd_cerase = 0;
  logic       cmd_susp = 0, cmd_resume = 0, cmd_reset = 0;
  logic [6:0] cmd_addr = '0, rd_addr = '0;
  logic [7:0] cmd_data = '0, erase_sel = '0, sect_lock = '0;
  logic       rd_en = 0;
  logic [7:0] rd_data;
  logic       rd_valid;
  int         checks = 0, failures = 0;

  fstat_flash dut (
    .clk(clk), .rst_n(rst_n), .cmd_prog(cmd_prog), .cmd_serase(cmd_serase),
    .cmd_cerase(cmd_cerase), .cmd_susp(cmd_susp), .cmd_resume(cmd_resume),
    .cmd_reset(cmd_reset), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .erase_sel(erase_sel), .sect_lock(sect_lock), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #4 clk = ~clk;

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_chk(string tag, logic [6:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic prog(logic [6:0] a, logic [7:0] v);
    @(negedge clk);
    cmd_prog = 1'b1; cmd_addr = a; cmd_data = v;
    @(negedge clk);
    cmd_prog = 1'b0;
  endtask

  task automatic serase(logic [7:0] sel);
    @(negedge clk);
    cmd_serase = 1'b1; erase_sel = sel;
    @(negedge clk);
    cmd_serase = 1'b0;
  endtask

  task automatic pulse_susp();   @(negedge clk); cmd_susp = 1;   @(negedge clk); cmd_susp = 0;   endtask
  task automatic pulse_resume(); @(negedge clk); cmd_resume = 1; @(negedge clk); cmd_resume = 0; endtask
  task automatic pulse_reset();  @(negedge clk); cmd_reset = 1;  @(negedge clk); cmd_reset = 0;  endtask
  task automatic pulse_chip();   @(negedge clk); cmd_cerase = 1; @(negedge clk); cmd_cerase = 0; endtask

  task automatic t_reset();
    logic [7:0] d;
    checks++;
    if (rd_valid !== 1'b0) begin failures++; $display("FAIL R1: rd_valid %0b expected 0", rd_valid); end
    @(negedge clk); rd_en = 1; rd_addr = 7'd0;
    @(negedge clk); rd_en = 0; d = rd_data;
    checks++;
    if (rd_valid !== 1'b1) begin failures++; $display("FAIL R1: rd_valid %0b expected 1", rd_valid); end
    check("R1 reset byte", d, 8'hFF);
    rd_chk("R1 reset last byte", 7'd127, 8'hFF);
  endtask

  task automatic t_program();
    prog(7'd3, 8'h5A);
    rd_chk("R2 busy bit7=0 data", 7'd3, 8'h80);
    tick(25);
    rd_chk("R3 done 5A", 7'd3, 8'h5A);
    prog(7'd3, 8'h12);
    tick(25);
    rd_chk("R3 AND result", 7'd3, 8'h12);
    prog(7'd20, 8'hC3);
    rd_chk("R2 busy bit7=1 data", 7'd20, 8'h00);
    tick(25);
    rd_chk("R3 done C3", 7'd20, 8'hC3);
    prog(7'd34, 8'h33);
    tick(25);
    rd_chk("R3 done 33", 7'd34, 8'h33);
  endtask

  task automatic t_timeout();
    prog(7'd3, 8'hFF);
    rd_chk("R9 busy before limit", 7'd3, 8'h00);
    tick(410);
    rd_chk("R9 timeout bit5", 7'd3, 8'h20);
    prog(7'd5, 8'h00);
    tick(30);
    rd_chk("R9 timeout sticky", 7'd3, 8'h20);
    pulse_reset();
    rd_chk("R9 reset no write", 7'd3, 8'h12);
    rd_chk("R10 ignored program", 7'd5, 8'hFF);
  endtask

  task automatic t_lock_prog();
    sect_lock = 8'h04;
    prog(7'd33, 8'h00);
    tick(200);
    rd_chk("R4 window polling", 7'd33, 8'h80);
    tick(60);
    rd_chk("R4 unchanged", 7'd33, 8'hFF);
  endtask

  task automatic t_partial_erase();
    serase(8'h05);
    rd_chk("R5 busy zero", 7'd3, 8'h00);
    prog(7'd60, 8'h00);
    tick(210);
    rd_chk("R5 erased", 7'd3, 8'hFF);
    rd_chk("R5 locked kept", 7'd34, 8'h33);
    rd_chk("R5 unselected kept", 7'd20, 8'hC3);
    rd_chk("R10 program during erase", 7'd60, 8'hFF);
  endtask

  task automatic t_lock_erase();
    serase(8'h04);
    tick(12400);
    rd_chk("R6 window polling", 7'd34, 8'h00);
    tick(120);
    rd_chk("R6 unchanged", 7'd34, 8'h33);
  endtask

  task automatic t_suspend();
    prog(7'd5, 8'h44);
    tick(25);
    serase(8'h03);
    tick(10);
    pulse_susp();
    rd_chk("R7 erasing sector", 7'd5, 8'h80);
    rd_chk("R7 erasing sector 1", 7'd20, 8'h80);
    rd_chk("R7 other sector", 7'd34, 8'h33);
    prog(7'd50, 8'h70);
    rd_chk("R8 busy in suspend", 7'd50, 8'h80);
    tick(25);
    rd_chk("R8 done in suspend", 7'd50, 8'h70);
    rd_chk("R8 back to suspend", 7'd5, 8'h80);
    pulse_resume();
    rd_chk("R7 resumed busy", 7'd5, 8'h00);
    tick(210);
    rd_chk("R7 erase complete", 7'd5, 8'hFF);
    rd_chk("R7 erase complete s1", 7'd20, 8'hFF);
    rd_chk("R8 kept", 7'd50, 8'h70);
  endtask

  task automatic t_chip();
    pulse_chip();
    rd_chk("R5 chip busy", 7'd50, 8'h00);
    tick(210);
    rd_chk("R5 chip erased", 7'd50, 8'hFF);
    rd_chk("R5 chip locked kept", 7'd34, 8'h33);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_timeout();
    t_lock_prog();
    t_partial_erase();
    t_lock_erase();
    t_suspend();
    t_chip();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule